// File: doc/BRIEF.md
# Interrupt Context Swap Controller

This block keeps the current program status word of a processor and performs the hardware context swap when an interrupt is accepted. Six interrupt classes exist, each with one fixed save slot (old word) and one fixed handler slot (new word). On acceptance the whole current word is written to the class's save slot, and the class's handler word becomes current. The instruction fetcher then reads the handler entry point from the low address field of the current word. A return command naming a class copies that class's save slot back into the current word, so the interrupted program resumes where it stopped.

The save slots are not a stack. A second acceptance of the same class overwrites the single save slot, and the first return link is lost. Requests are captured as pulses into pending bits. An accepted request is cleared from its pending bit. A request whose class is masked stays pending until a return lifts the mask. Masking is driven by two small state machines. The first is the external/I-O group machine with states GRP_FREE, GRP_EXT_BUSY and GRP_IO_BUSY. Accepting external moves GRP_FREE to GRP_EXT_BUSY, and accepting I/O moves GRP_FREE to GRP_IO_BUSY. A return of the owning class moves either busy state back to GRP_FREE. The second is the machine-check machine with states MCK_FREE and MCK_BUSY. Accepting a machine check moves MCK_FREE to MCK_BUSY, and a machine-check return moves MCK_BUSY back to MCK_FREE. A handler word for any class is loaded through a write port.

Top module: `psw_swap_ctrl`

## Requirements
- R1: After reset the current word equals the RESET_PSW parameter, the taken output is zero, the mask output is zero, and all save and handler slots are zero.
- R2: In the cycle after a class is accepted, the current word equals that class's handler slot. The previous current word is held in that class's save slot.
- R3: The instruction address output always equals the low ADDR_W bits of the current word, so after a swap it is the handler entry point.
- R4: A return with class code 0 to 5 loads that class's save slot into the current word in the next cycle. Return codes 6 and 7 are ignored and do not block acceptance.
- R5: While the group machine is in GRP_IO_BUSY, I/O and external requests are not accepted, and mask bits 4 and 3 are set.
- R6: While the group machine is in GRP_EXT_BUSY, external and I/O requests are not accepted, and mask bits 3 and 4 are set.
- R7: While the machine-check machine is in MCK_BUSY, machine-check requests are not accepted, and mask bit 0 is set.
- R8: Supervisor call, program and restart are never masked (mask bits 1, 2 and 5 are always zero).
- R9: A masked request stays pending and is accepted once its mask clears, with no new pulse.
- R10: When several unmasked requests are pending, exactly one is accepted per cycle. The lowest bit index wins, which gives the order machine check, supervisor call, program, external, I/O, restart.
- R11: Two acceptances of one class with no return between them overwrite that class's save slot. A later return then restores the first handler's word, not the interrupted program's word.
- R12: In a cycle with a valid return (code 0 to 5) nothing is accepted. The masks of the matching class are released at that same clock edge, so a waiting request can be accepted in the next cycle.
- R13: The taken output is one-hot with bit order 0 machine check, 1 supervisor call, 2 program, 3 external, 4 I/O, 5 restart. It is high for the single cycle in which the new word is already current. The request and mask vectors use the same bit order, and class codes 0 to 5 follow it.
- R14: A write loads the handler slot of code 0 to 5 at the next edge. A swap of the same class in the write cycle still uses the slot's earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 6 | Per-class request pulses |
| ret_valid_i | input | 1 | Return command strobe |
| ret_class_i | input | 3 | Class code of the return |
| wr_valid_i | input | 1 | Handler slot write strobe |
| wr_class_i | input | 3 | Class code of the slot written |
| wr_data_i | input | PSW_W | Handler word to store |
| cur_psw_o | output | PSW_W | Current program status word |
| instr_addr_o | output | ADDR_W | Instruction address field of the current word |
| taken_o | output | 6 | One-hot accepted class, one cycle |
| mask_o | output | 6 | Classes currently masked |

## Verification
The assertions assume that a return is issued only by software that follows the class discipline. A return of a class whose handler is not active is still legal, and it only restores a save slot. They also assume request pulses may arrive in any cycle, including return cycles and cycles that already hold a pending bit of the same class. The stimulus drives every input one full cycle at a time, away from the clock edge. It sweeps all 63 non-empty request patterns and drains each one with returns chosen from the bench's own view of which handler holds a mask. Invalid return codes and writes that collide with swaps are injected in separate cycles.

// File: rtl/psw_swap_pkg.sv
package psw_swap_pkg;
    localparam int NUM_CLS = 6;
    localparam int CLS_W   = 3;

    // Class index = bit position = priority rank (0 highest)
    localparam int CLS_MCK = 0;
    localparam int CLS_SVC = 1;
    localparam int CLS_PGM = 2;
    localparam int CLS_EXT = 3;
    localparam int CLS_IO  = 4;
    localparam int CLS_RST = 5;

    typedef enum logic [1:0] {
        GRP_FREE     = 2'd0,
        GRP_EXT_BUSY = 2'd1,
        GRP_IO_BUSY  = 2'd2
    } grp_state_e;

    typedef enum logic {
        MCK_FREE = 1'b0,
        MCK_BUSY = 1'b1
    } mck_state_e;
endpackage

// File: rtl/psw_take_arbiter.sv
module psw_take_arbiter
    import psw_swap_pkg::*;
#(
    parameter int N = NUM_CLS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic         hold_i,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] grant_o
);
    logic [N-1:0] pend_q;
    logic [N-1:0] pend_all;
    logic [N-1:0] elig;
    logic [N-1:0] seen;

    assign pend_all = pend_q | req_i;
    assign elig     = pend_all & ~mask_i & {N{~hold_i}};

    // Fixed priority: lowest index wins
    for (genvar g = 0; g < N; g++) begin : g_prio
        if (g == 0) begin : g_first
            assign grant_o[g] = elig[g];
            assign seen[g]    = elig[g];
        end else begin : g_rest
            assign grant_o[g] = elig[g] & ~seen[g-1];
            assign seen[g]    = seen[g-1] | elig[g];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_all & ~grant_o;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R10

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_all[g] && !grant_o[g]) |=> pend_q[g]); // R9
    end
endmodule

// File: rtl/psw_mask_fsm.sv
module psw_mask_fsm
    import psw_swap_pkg::*;
#(
    parameter int N  = NUM_CLS,
    parameter int CW = CLS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_ext_i,
    input  logic          take_io_i,
    input  logic          take_mck_i,
    input  logic          ret_ok_i,
    input  logic [CW-1:0] ret_class_i,
    output logic [N-1:0]  mask_o
);
    grp_state_e grp_q, grp_d;
    mck_state_e mck_q, mck_d;

    logic ret_ext, ret_io, ret_mck;
    assign ret_ext = ret_ok_i && (ret_class_i == CW'(CLS_EXT));
    assign ret_io  = ret_ok_i && (ret_class_i == CW'(CLS_IO));
    assign ret_mck = ret_ok_i && (ret_class_i == CW'(CLS_MCK));

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q <= GRP_FREE;
            mck_q <= MCK_FREE;
        end else begin
            grp_q <= grp_d;
            mck_q <= mck_d;
        end
    end

    // Transitions
    always_comb begin
        grp_d = grp_q;
        unique case (grp_q)
            GRP_FREE: begin
                if (take_ext_i)     grp_d = GRP_EXT_BUSY;
                else if (take_io_i) grp_d = GRP_IO_BUSY;
            end
            GRP_EXT_BUSY: if (ret_ext) grp_d = GRP_FREE;
            GRP_IO_BUSY:  if (ret_io)  grp_d = GRP_FREE;
            default:      grp_d = GRP_FREE;
        endcase

        mck_d = mck_q;
        unique case (mck_q)
            MCK_FREE: if (take_mck_i) mck_d = MCK_BUSY;
            MCK_BUSY: if (ret_mck)    mck_d = MCK_FREE;
            default:  mck_d = MCK_FREE;
        endcase
    end

    // Outputs
    always_comb begin
        mask_o          = '0;
        mask_o[CLS_EXT] = (grp_q != GRP_FREE);
        mask_o[CLS_IO]  = (grp_q != GRP_FREE);
        mask_o[CLS_MCK] = (mck_q == MCK_BUSY);
    end

    AST_EXT_RET_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_q == GRP_EXT_BUSY && ret_ext) |=> !mask_o[CLS_EXT]); // R12
    AST_IO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_q == GRP_IO_BUSY && !ret_io) |=> (mask_o[CLS_IO] && mask_o[CLS_EXT])); // R5
    AST_EXT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_q == GRP_EXT_BUSY && !ret_ext) |=> (mask_o[CLS_IO] && mask_o[CLS_EXT])); // R6
    AST_MCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mck_q == MCK_BUSY && !ret_mck) |=> mask_o[CLS_MCK]); // R7
endmodule

// File: rtl/psw_slot_bank.sv
module psw_slot_bank
    import psw_swap_pkg::*;
#(
    parameter int PSW_W = 64,
    parameter int N     = NUM_CLS,
    parameter int CW    = CLS_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            save_i,
    input  logic [PSW_W-1:0]        cur_i,
    input  logic                    wr_valid_i,
    input  logic [CW-1:0]           wr_class_i,
    input  logic [PSW_W-1:0]        wr_data_i,
    output logic [N-1:0][PSW_W-1:0] old_o,
    output logic [N-1:0][PSW_W-1:0] new_o
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                old_o[g] <= '0;
                new_o[g] <= '0;
            end else begin
                if (save_i[g])
                    old_o[g] <= cur_i;
                if (wr_valid_i && (wr_class_i == CW'(g)))
                    new_o[g] <= wr_data_i;
            end
        end

        AST_OLD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            save_i[g] |=> (old_o[g] == $past(cur_i))); // R2
    end
endmodule

// File: rtl/psw_swap_ctrl.sv
module psw_swap_ctrl
    import psw_swap_pkg::*;
#(
    parameter int              PSW_W     = 64,
    parameter int              ADDR_W    = 24,
    parameter logic [PSW_W-1:0] RESET_PSW = PSW_W'(64'h0000_0001_0000_0400)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        req_i,
    input  logic              ret_valid_i,
    input  logic [2:0]        ret_class_i,
    input  logic              wr_valid_i,
    input  logic [2:0]        wr_class_i,
    input  logic [PSW_W-1:0]  wr_data_i,
    output logic [PSW_W-1:0]  cur_psw_o,
    output logic [ADDR_W-1:0] instr_addr_o,
    output logic [5:0]        taken_o,
    output logic [5:0]        mask_o
);
    localparam int N  = NUM_CLS;
    localparam int CW = CLS_W;

    logic [PSW_W-1:0]        cur_q, cur_d;
    logic [N-1:0]            taken_q;
    logic [N-1:0]            grant;
    logic [N-1:0]            mask;
    logic [N-1:0][PSW_W-1:0] old_s, new_s;
    logic [PSW_W-1:0]        sel_new, sel_old;
    logic                    ret_ok;

    assign ret_ok = ret_valid_i && (ret_class_i < CW'(N));

    psw_take_arbiter #(.N(N)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .hold_i  (ret_ok),
        .mask_i  (mask),
        .grant_o (grant)
    );

    psw_mask_fsm #(.N(N), .CW(CW)) u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_ext_i  (grant[CLS_EXT]),
        .take_io_i   (grant[CLS_IO]),
        .take_mck_i  (grant[CLS_MCK]),
        .ret_ok_i    (ret_ok),
        .ret_class_i (ret_class_i),
        .mask_o      (mask)
    );

    psw_slot_bank #(.PSW_W(PSW_W), .N(N), .CW(CW)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .save_i     (grant),
        .cur_i      (cur_q),
        .wr_valid_i (wr_valid_i),
        .wr_class_i (wr_class_i),
        .wr_data_i  (wr_data_i),
        .old_o      (old_s),
        .new_o      (new_s)
    );

    // Slot selection and next-word choice
    always_comb begin
        sel_new = '0;
        sel_old = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i])
                sel_new = new_s[i];
            if (ret_class_i == CW'(i))
                sel_old = old_s[i];
        end
        cur_d = cur_q;
        if (ret_ok)
            cur_d = sel_old;
        else if (|grant)
            cur_d = sel_new;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= RESET_PSW;
            taken_q <= '0;
        end else begin
            cur_q   <= cur_d;
            taken_q <= grant;
        end
    end

    assign cur_psw_o    = cur_q;
    assign instr_addr_o = cur_q[ADDR_W-1:0];
    assign taken_o      = taken_q;
    assign mask_o       = mask;

    AST_MASKED_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & mask) == '0)); // R5
    AST_NEVER_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_o[CLS_SVC] && !mask_o[CLS_PGM] && !mask_o[CLS_RST])); // R8
    AST_TAKEN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(taken_o)); // R13
    AST_RET_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_ok |=> (taken_o == '0)); // R12
    AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_ok |=> (cur_psw_o == $past(sel_old))); // R4
    AST_SWAP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |=> (cur_psw_o == $past(sel_new))); // R2
endmodule

// File: tb/psw_swap_ctrl_tb.sv
module psw_swap_ctrl_tb;
    localparam int PW = 64;
    localparam int AW = 24;
    localparam logic [PW-1:0] RST_WORD = 64'h0000_0001_0000_0400;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [5:0]    req_i;
    logic          ret_valid_i;
    logic [2:0]    ret_class_i;
    logic          wr_valid_i;
    logic [2:0]    wr_class_i;
    logic [PW-1:0] wr_data_i;
    logic [PW-1:0] cur_psw_o;
    logic [AW-1:0] instr_addr_o;
    logic [5:0]    taken_o;
    logic [5:0]    mask_o;

    always #10 clk = ~clk;

    psw_swap_ctrl #(.PSW_W(PW), .ADDR_W(AW), .RESET_PSW(RST_WORD)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ret_valid_i(ret_valid_i),
        .ret_class_i(ret_class_i), .wr_valid_i(wr_valid_i), .wr_class_i(wr_class_i),
        .wr_data_i(wr_data_i), .cur_psw_o(cur_psw_o), .instr_addr_o(instr_addr_o),
        .taken_o(taken_o), .mask_o(mask_o)
    );

    int checks = 0;
    int fails  = 0;

    // Bench view of the block, from the requirements
    logic [PW-1:0] m_cur;
    logic [PW-1:0] m_old [6];
    logic [PW-1:0] m_new [6];
    logic [5:0]    m_pend, m_taken, m_mask;
    int            m_grp;   // 0 free, 1 external active, 2 I/O active
    logic          m_mck;

    function automatic logic [PW-1:0] hword(int c, int v);
        return {32'hA5A5_0000 + 32'(c) + 32'(v << 8), 8'h00, 24'h00_8000 + 24'(c * 256) + 24'(v * 16)};
    endfunction

    task automatic chk(string tag, string what, logic [PW-1:0] act, logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic void model_mask();
        m_mask = '0;
        if (m_grp != 0) begin m_mask[3] = 1'b1; m_mask[4] = 1'b1; end
        if (m_mck) m_mask[0] = 1'b1;
    endfunction

    task automatic step(logic [5:0] rq, logic rv, logic [2:0] rc,
                        logic wv, logic [2:0] wc, logic [PW-1:0] wd, string tag);
        logic [5:0] elig;
        logic       found;
        req_i = rq; ret_valid_i = rv; ret_class_i = rc;
        wr_valid_i = wv; wr_class_i = wc; wr_data_i = wd;
        m_pend  = m_pend | rq;
        m_taken = '0;
        if (rv && rc < 3'd6) begin
            m_cur = m_old[rc];
            if (rc == 3'd3 && m_grp == 1) m_grp = 0;
            if (rc == 3'd4 && m_grp == 2) m_grp = 0;
            if (rc == 3'd0) m_mck = 1'b0;
        end else begin
            elig  = m_pend & ~m_mask;
            found = 1'b0;
            for (int k = 0; k < 6; k++) begin
                if (!found && elig[k]) begin
                    found = 1'b1;
                    m_taken[k] = 1'b1;
                    m_pend[k]  = 1'b0;
                    m_old[k]   = m_cur;
                    m_cur      = m_new[k];
                    if (k == 3) m_grp = 1;
                    if (k == 4) m_grp = 2;
                    if (k == 0) m_mck = 1'b1;
                end
            end
        end
        if (wv && wc < 3'd6) m_new[wc] = wd;
        model_mask();
        @(posedge clk);
        @(negedge clk);
        req_i = '0; ret_valid_i = 1'b0; wr_valid_i = 1'b0;
        chk(tag, "psw", cur_psw_o, m_cur);
        chk("R3", "addr", PW'(instr_addr_o), PW'(m_cur[AW-1:0]));
        chk(tag, "taken", PW'(taken_o), PW'(m_taken));
        chk(tag, "mask", PW'(mask_o), PW'(m_mask));
    endtask

    task automatic idle(string tag);
        step('0, 1'b0, 3'd0, 1'b0, 3'd0, '0, tag);
    endtask
    task automatic pulse(logic [5:0] rq, string tag);
        step(rq, 1'b0, 3'd0, 1'b0, 3'd0, '0, tag);
    endtask
    task automatic ret(logic [2:0] c, string tag);
        step('0, 1'b1, c, 1'b0, 3'd0, '0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_i = '0; ret_valid_i = 1'b0; ret_class_i = '0;
        wr_valid_i = 1'b0; wr_class_i = '0; wr_data_i = '0;
        m_cur = RST_WORD; m_pend = '0; m_taken = '0; m_grp = 0; m_mck = 1'b0;
        for (int c = 0; c < 6; c++) begin m_old[c] = '0; m_new[c] = '0; end
        model_mask();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "psw", cur_psw_o, RST_WORD);
        chk("R1", "taken", PW'(taken_o), '0);
        chk("R1", "mask", PW'(mask_o), '0);
        // R1 slots are zero: taking restart before any write loads zero
        pulse(6'b100000, "R1");
        ret(3'd5, "R1");

        // R14 load every handler slot
        for (int c = 0; c < 6; c++)
            step('0, 1'b0, 3'd0, 1'b1, 3'(c), hword(c, 1), "R14");

        // R2/R13/R4 sweep: take each class alone, idle, return
        for (int c = 0; c < 6; c++) begin
            pulse(6'(1 << c), "R2");
            chk("R2", "entry", PW'(instr_addr_o), PW'(hword(c, 1) & 64'hFF_FFFF));
            idle("R13");
            ret(3'(c), "R4");
        end

        // R5 I/O handler masks I/O and external
        pulse(6'b010000, "R5");
        pulse(6'b011000, "R5");
        idle("R5");
        ret(3'd4, "R12");
        idle("R6");            // external accepted now
        idle("R6");            // I/O still waiting
        ret(3'd3, "R12");
        idle("R9");            // I/O accepted
        ret(3'd4, "R9");

        // R6 external handler; R8 supervisor call passes
        pulse(6'b001000, "R6");
        pulse(6'b010010, "R8");
        ret(3'd1, "R8");
        idle("R6");
        ret(3'd3, "R6");
        idle("R9");
        ret(3'd4, "R9");

        // R7 machine check masks itself; program and restart pass
        pulse(6'b000001, "R7");
        pulse(6'b100101, "R8");
        idle("R8");
        idle("R7");
        ret(3'd0, "R7");
        idle("R9");
        ret(3'd0, "R7");

        // R11 same class twice loses the first return link
        pulse(6'b000010, "R11");
        pulse(6'b000010, "R11");
        ret(3'd1, "R11");
        chk("R11", "lost link", cur_psw_o, hword(1, 1));

        // R4 invalid return codes ignored, acceptance not blocked
        ret(3'd6, "R4");
        step(6'b000100, 1'b1, 3'd7, 1'b0, 3'd0, '0, "R4");
        ret(3'd2, "R4");

        // R14 write colliding with a swap of the same class
        step(6'b100000, 1'b0, 3'd0, 1'b1, 3'd5, hword(5, 2), "R14");
        ret(3'd5, "R14");
        pulse(6'b100000, "R14");
        ret(3'd5, "R14");

        // R12 request arriving in a return cycle waits one cycle
        step(6'b000010, 1'b1, 3'd2, 1'b0, 3'd0, '0, "R12");
        idle("R12");
        ret(3'd1, "R12");

        // R10 every request pattern, drained with returns
        for (int m = 1; m < 64; m++) begin
            pulse(6'(m), "R10");
            for (int k = 0; k < 20; k++) begin
                if (m_pend != '0 || m_grp != 0 || m_mck) begin
                    if (m_grp == 1)      ret(3'd3, "R9");
                    else if (m_grp == 2) ret(3'd4, "R9");
                    else if (m_mck)      ret(3'd0, "R9");
                    else                 idle("R10");
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule